// File: doc/BRIEF.md
# Queued SPI Slave Controller

This block is an SPI slave that works through a queue of sixteen words instead of a single shift register. A host preloads transmit words into a transmit segment, sets a start entry and an end entry, and enables the block. Each time an external master clocks a word through, the block returns the transmit word for the current entry, most significant bit first. It files the word it received into the matching receive slot and then moves on to the next entry. The block records the entry that completed last. It raises a completion flag when the end entry finishes. It then either stops, or it returns to entry 0 and keeps running.

A word can arrive in pieces: if the master releases slave select part of the way through a word, the bits received so far are kept, and the next selection continues the same entry. Slave select may also stay low across many entries. The SCK, MOSI and slave-select pins are brought into the system clock domain through two-flop synchronizers. The system clock must therefore run at least four times faster than SCK. The host uses a simple synchronous register port with a one-cycle read latency.

Top module: `spq_slave`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, `miso_oe` is 0 and `irq` is 0.
- R2: While the block is enabled and the synchronized slave select is low, `miso_oe` is 1 and `miso` carries bit (N-1-k) of the transmit entry at the working pointer, where N is the word length and k is the number of bits already received for that entry. At all other times `miso_oe` is 0.
- R3: The word length comes from control bits [11:8]. The value 0 selects 16 bits, values 8 to 15 select that many bits, and values 1 to 7 select 8 bits. A word shorter than 16 bits is stored right-justified, with zeros above it.
- R4: When the N-th bit of an entry is sampled, the received word is written to the receive entry at the working pointer. That pointer is copied to status bits [3:0], the working pointer advances by one, and the next transmit entry drives `miso`.
- R5: If slave select goes high before an entry is complete, the bits already received are kept, and the next selection goes on filling the same entry.
- R6: If slave select stays low past the end of an entry, the next bit is the first bit of the next entry.
- R7: A host write to the start register (address 0x21) takes effect at the next falling edge of slave select. That edge loads the working pointer and discards any partial word. With no such write, the working pointer carries over unchanged.
- R8: MOSI is sampled on the rising SCK edge when control bit 3 (clock idle level) equals control bit 4 (phase), and on the falling edge otherwise. `miso` changes only after a sampling edge, so it is stable at the master's sampling edge in all four modes.
- R9: When the entry equal to the end register (address 0x22) completes, status bit 4 (flag) is set. `irq` equals the flag ANDed with control bit 2.
- R10: With control bit 1 (wraparound) clear, completing the end entry clears control bit 0 (enable), and the working pointer moves to end+1. While enable is 0, SCK activity changes no receive entry and `miso_oe` stays 0.
- R11: With wraparound set, completing the end entry moves the working pointer to 0 and enable stays 1. The flag stays set until the host writes status with bit 4 set.
- R12: Host map, with address bits [5:4] selecting the segment: 0 is the transmit entries (read/write), 1 is the receive entries (read only), and 2 is the registers at 0x20 control, 0x21 start, 0x22 end and 0x23 status. Read data appears one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| h_en | input | 1 | Host access request |
| h_we | input | 1 | Host write when 1, read when 0 |
| h_addr | input | 6 | Host address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, registered |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ssn | input | 1 | Slave select, active low |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad |
| irq | output | 1 | Completion interrupt |

## Verification
The queue is exercised with whole 16-bit words under one long selection. This separates correct pointer advance from an off-by-one in either the transmit entry or the receive entry. Short words and the out-of-range length code show whether right-justification and the length decode are right. A word split across two selections, followed by words clocked with select held low, tells keeping the partial word apart from restarting it, and tells rolling into the next entry apart from stalling. Writing a new start pointer after a partial word, then running all four clock modes and a wraparound pass with a flag clear, separates pointer reload, edge selection, and stopping versus wrapping at the end entry.

// File: rtl/spq_pkg.sv
package spq_pkg;

    localparam int DW = 16;
    localparam int QD = 16;
    localparam int PW = $clog2(QD);
    localparam int CW = $clog2(DW) + 1;
    localparam int AW = PW + 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEG_TX  = 2'd0,
        SEG_RX  = 2'd1,
        SEG_REG = 2'd2,
        SEG_NONE = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_START = 2'd1,
        REG_END   = 2'd2,
        REG_STAT  = 2'd3
    } reg_e;

    typedef struct packed {
        logic       en;
        logic       wrap;
        logic       ie;
        logic       cpol;
        logic       cpha;
        logic [3:0] len;
    } ctrl_t;

    function automatic logic [CW-1:0] decode_len(input logic [3:0] f);
        if (f == 4'd0)
            return CW'(DW);
        else if (f < 4'd8)
            return CW'(8);
        else
            return CW'(f);
    endfunction

endpackage

// File: rtl/spq_sync.sv
module spq_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spq_serial.sv
module spq_serial #(
    parameter int DW_P = 16,
    localparam int CW_P = $clog2(DW_P) + 1,
    localparam int IW_P = $clog2(DW_P)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sck_s,
    input  logic            mosi_s,
    input  logic            ssn_s,
    input  logic            run,
    input  logic            cpol,
    input  logic            cpha,
    input  logic [CW_P-1:0] nbits,
    input  logic            restart,
    input  logic [DW_P-1:0] tx_word,
    output logic            miso_bit,
    output logic            done,
    output logic [DW_P-1:0] rx_word
);
    logic            sck_q;
    logic [CW_P-1:0] cnt;
    logic [DW_P-1:0] sh;
    logic            rise, fall, samp;
    logic [CW_P-1:0] next_cnt;
    logic [CW_P-1:0] idx;

    assign rise     = sck_s & ~sck_q;
    assign fall     = ~sck_s & sck_q;
    assign samp     = run & ~ssn_s & ((cpol == cpha) ? rise : fall);
    assign next_cnt = cnt + 1'b1;
    assign idx      = nbits - cnt - 1'b1;
    assign miso_bit = tx_word[idx[IW_P-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            sck_q <= sck_s;
            done  <= 1'b0;
            if (restart) begin
                cnt <= '0;
                sh  <= '0;
            end else if (samp) begin
                if (next_cnt >= nbits) begin
                    done    <= 1'b1;
                    rx_word <= {sh[DW_P-2:0], mosi_s};
                    cnt     <= '0;
                    sh      <= '0;
                end else begin
                    cnt <= next_cnt;
                    sh  <= {sh[DW_P-2:0], mosi_s};
                end
            end
        end
    end

    // R5: a deselected interface keeps the partial bit count
    a_r5_hold_partial: assert property (@(posedge clk) disable iff (rst)
        $past(ssn_s) |-> $stable(cnt));

    // R8: the bit count only moves after a sampling edge or a reload
    a_r8_edge_only: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> $past(samp || restart));

    // R4: a completed word never leaves a partial count behind
    a_r4_word_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == '0));
endmodule

// File: rtl/spq_ctrl.sv
module spq_ctrl
    import spq_pkg::*;
#(
    parameter int DW_P = 16,
    parameter int QD_P = 16,
    localparam int PW_P = $clog2(QD_P),
    localparam int AW_P = PW_P + 2,
    localparam int CW_P = $clog2(DW_P) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            h_en,
    input  logic            h_we,
    input  logic [AW_P-1:0] h_addr,
    input  logic [DW_P-1:0] h_wdata,
    output logic [DW_P-1:0] h_rdata,
    input  logic            ssn_s,
    input  logic            done,
    input  logic [DW_P-1:0] rx_word,
    output logic            en,
    output logic            cpol,
    output logic            cpha,
    output logic [CW_P-1:0] nbits,
    output logic            restart,
    output logic [DW_P-1:0] tx_word,
    output logic            irq
);
    logic [DW_P-1:0] tx_mem [QD_P];
    logic [DW_P-1:0] rx_mem [QD_P];
    ctrl_t           ctl;
    logic [PW_P-1:0] wp, newq, endq, cptr;
    logic            pend, flag, ssn_q;
    logic [PW_P-1:0] hidx;
    seg_e            seg;
    reg_e            rsel;
    logic [DW_P-1:0] ctrl_word, stat_word, rd_mux;
    logic            at_end;

    assign hidx    = h_addr[PW_P-1:0];
    assign seg     = seg_e'(h_addr[AW_P-1 -: 2]);
    assign rsel    = reg_e'(h_addr[1:0]);
    assign restart = ssn_q & ~ssn_s & pend;
    assign at_end  = (wp == endq);
    assign tx_word = tx_mem[wp];
    assign en      = ctl.en;
    assign cpol    = ctl.cpol;
    assign cpha    = ctl.cpha;
    assign nbits   = CW_P'(decode_len(ctl.len));
    assign irq     = flag & ctl.ie;

    always_comb begin
        ctrl_word        = '0;
        ctrl_word[0]     = ctl.en;
        ctrl_word[1]     = ctl.wrap;
        ctrl_word[2]     = ctl.ie;
        ctrl_word[3]     = ctl.cpol;
        ctrl_word[4]     = ctl.cpha;
        ctrl_word[11:8]  = ctl.len;
        stat_word        = '0;
        stat_word[PW_P-1:0] = cptr;
        stat_word[PW_P]  = flag;
        rd_mux = '0;
        case (seg)
            SEG_TX:  rd_mux = tx_mem[hidx];
            SEG_RX:  rd_mux = rx_mem[hidx];
            SEG_REG: begin
                case (rsel)
                    REG_CTRL:  rd_mux = ctrl_word;
                    REG_START: rd_mux = DW_P'(newq);
                    REG_END:   rd_mux = DW_P'(endq);
                    REG_STAT:  rd_mux = stat_word;
                    default:   rd_mux = '0;
                endcase
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < QD_P; i++) begin
                tx_mem[i] <= '0;
                rx_mem[i] <= '0;
            end
            ctl     <= '0;
            wp      <= '0;
            newq    <= '0;
            endq    <= '0;
            cptr    <= '0;
            pend    <= 1'b0;
            flag    <= 1'b0;
            ssn_q   <= 1'b1;
            h_rdata <= '0;
        end else begin
            ssn_q <= ssn_s;
            if (restart) begin
                wp   <= newq;
                pend <= 1'b0;
            end
            if (h_en && !h_we)
                h_rdata <= rd_mux;
            if (h_en && h_we) begin
                case (seg)
                    SEG_TX: tx_mem[hidx] <= h_wdata;
                    SEG_REG: begin
                        case (rsel)
                            REG_CTRL: begin
                                ctl.en   <= h_wdata[0];
                                ctl.wrap <= h_wdata[1];
                                ctl.ie   <= h_wdata[2];
                                ctl.cpol <= h_wdata[3];
                                ctl.cpha <= h_wdata[4];
                                ctl.len  <= h_wdata[11:8];
                            end
                            REG_START: begin
                                newq <= h_wdata[PW_P-1:0];
                                pend <= 1'b1;
                            end
                            REG_END:  endq <= h_wdata[PW_P-1:0];
                            REG_STAT: if (h_wdata[PW_P]) flag <= 1'b0;
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
            if (done && ctl.en) begin
                rx_mem[wp] <= rx_word;
                cptr       <= wp;
                if (at_end) begin
                    flag <= 1'b1;
                    if (ctl.wrap) begin
                        wp <= '0;
                    end else begin
                        wp     <= wp + 1'b1;
                        ctl.en <= 1'b0;
                    end
                end else begin
                    wp <= wp + 1'b1;
                end
            end
        end
    end

    // R9: finishing the end entry raises the flag
    a_r9_flag_at_end: assert property (@(posedge clk) disable iff (rst)
        (done && ctl.en && at_end) |=> flag);

    // R10: without wraparound the controller disables itself at the end
    a_r10_stop_at_end: assert property (@(posedge clk) disable iff (rst)
        (done && ctl.en && at_end && !ctl.wrap) |=> !ctl.en);

    // R11: with wraparound the pointer returns to entry 0
    a_r11_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (done && ctl.en && at_end && ctl.wrap) |=> (wp == '0));

    // R4: the completed pointer records the entry just finished
    a_r4_record_entry: assert property (@(posedge clk) disable iff (rst)
        (done && ctl.en) |=> (cptr == $past(wp)));

    // R7: a pending start pointer is loaded on selection
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        restart |=> (wp == $past(newq)));
endmodule

// File: rtl/spq_slave.sv
module spq_slave
    import spq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          h_en,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          sck,
    input  logic          mosi,
    input  logic          ssn,
    output logic          miso,
    output logic          miso_oe,
    output logic          irq
);
    logic          sck_s, mosi_s, ssn_s;
    logic          en, cpol, cpha, restart, done, miso_bit;
    logic [CW-1:0] nbits;
    logic [DW-1:0] tx_word, rx_word;

    spq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ssn, mosi, sck}),
        .q   ({ssn_s, mosi_s, sck_s})
    );

    spq_serial #(.DW_P(DW)) u_serial (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .ssn_s    (ssn_s),
        .run      (en),
        .cpol     (cpol),
        .cpha     (cpha),
        .nbits    (nbits),
        .restart  (restart),
        .tx_word  (tx_word),
        .miso_bit (miso_bit),
        .done     (done),
        .rx_word  (rx_word)
    );

    spq_ctrl #(.DW_P(DW), .QD_P(QD)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .h_en    (h_en),
        .h_we    (h_we),
        .h_addr  (h_addr),
        .h_wdata (h_wdata),
        .h_rdata (h_rdata),
        .ssn_s   (ssn_s),
        .done    (done),
        .rx_word (rx_word),
        .en      (en),
        .cpol    (cpol),
        .cpha    (cpha),
        .nbits   (nbits),
        .restart (restart),
        .tx_word (tx_word),
        .irq     (irq)
    );

    assign miso_oe = en & ~ssn_s;
    assign miso    = miso_oe & miso_bit;

    // R2: the pad is released whenever the controller is disabled
    a_r2_release: assert property (@(posedge clk) disable iff (rst)
        !en |-> !miso_oe && !miso);
endmodule

// File: tb/tb_spq_slave.sv
`timescale 1ns/1ps
module tb_spq_slave;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_en = 1'b0, h_we = 1'b0;
    logic [5:0]  h_addr = '0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        sck = 1'b0, mosi = 1'b0, ssn = 1'b1;
    logic        miso, miso_oe, irq;

    always #2.5 clk = ~clk;

    spq_slave dut (
        .clk(clk), .rst(rst), .h_en(h_en), .h_we(h_we), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .sck(sck), .mosi(mosi),
        .ssn(ssn), .miso(miso), .miso_oe(miso_oe), .irq(irq)
    );

    int errs = 0, checks = 0;
    bit fin = 0;

    // behavioural reference state
    logic [15:0] m_tx [16];
    logic [15:0] m_rx [16];
    int   m_wp = 0, m_cptr = 0, m_end = 0, m_new = 0, m_n = 16, m_cnt = 0;
    bit   m_pend = 0, m_flag = 0, m_en = 0, m_wrap = 0, m_ie = 0, m_cpol = 0, m_cpha = 0;
    logic [15:0] m_acc = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        h_en = 1; h_we = 1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_en = 0; h_we = 0;
    endtask

    task automatic hread(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        h_en = 1; h_we = 0; h_addr = a;
        @(negedge clk);
        h_en = 0;
        d = h_rdata;
    endtask

    function automatic int len_of(input int f);
        if (f == 0) return 16;
        if (f < 8) return 8;
        return f;
    endfunction

    task automatic set_ctrl(input bit en, input bit wr, input bit ie,
                            input bit cp, input bit ph, input int lf);
        @(negedge clk);
        sck = cp;
        hwrite(6'h20, 16'((lf << 8) | (ph << 4) | (cp << 3) | (ie << 2) | (wr << 1) | en));
        m_en = en; m_wrap = wr; m_ie = ie; m_cpol = cp; m_cpha = ph; m_n = len_of(lf);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_start(input int p);
        hwrite(6'h21, 16'(p));
        m_new = p; m_pend = 1;
    endtask

    task automatic set_end(input int p);
        hwrite(6'h22, 16'(p));
        m_end = p;
    endtask

    task automatic clear_flag();
        hwrite(6'h23, 16'h0010);
        m_flag = 0;
    endtask

    task automatic ss_low();
        @(negedge clk);
        ssn = 0;
        if (m_pend) begin
            m_wp = m_new; m_cnt = 0; m_acc = '0; m_pend = 0;
        end
        repeat (H) @(negedge clk);
    endtask

    task automatic ss_high();
        @(negedge clk);
        ssn = 1;
        repeat (H) @(negedge clk);
    endtask

    task automatic model_sample(input logic b);
        if (!m_en) return;
        m_acc = {m_acc[14:0], b};
        m_cnt++;
        if (m_cnt >= m_n) begin
            m_rx[m_wp] = m_acc;
            m_cptr = m_wp;
            if (m_wp == m_end) begin
                m_flag = 1;
                if (m_wrap) m_wp = 0;
                else begin m_wp = (m_wp + 1) % 16; m_en = 0; end
            end else m_wp = (m_wp + 1) % 16;
            m_cnt = 0; m_acc = '0;
        end
    endtask

    // one bit: miso is read just before the sampling edge (R2, R8)
    task automatic xbit(input logic b, input string tag);
        logic got, goe, exp;
        if (!m_cpha) begin
            mosi = b;
            repeat (H) @(negedge clk);
            got = miso; goe = miso_oe;
            sck = ~m_cpol;
        end else begin
            sck = ~m_cpol;
            mosi = b;
            repeat (H) @(negedge clk);
            got = miso; goe = miso_oe;
            sck = m_cpol;
        end
        if (m_en) begin
            exp = m_tx[m_wp][m_n - 1 - m_cnt];
            chk(goe === 1'b1 && got === exp, {tag, " R2 R8 miso bit"}, {goe, got}, {1'b1, exp});
        end else begin
            chk(goe === 1'b0, {tag, " R10 miso_oe idle"}, goe, 0);
        end
        model_sample(b);
        repeat (H) @(negedge clk);
        if (!m_cpha) sck = m_cpol;
    endtask

    task automatic xbits(input logic [15:0] w, input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) xbit(w[i], tag);
    endtask

    task automatic cmp_rx(input int e, input string tag);
        logic [15:0] d;
        hread(6'(16 + e), d);
        chk(d === m_rx[e], tag, d, m_rx[e]);
    endtask

    task automatic cmp_stat(input string tag);
        logic [15:0] d;
        logic [15:0] exp;
        repeat (4) @(negedge clk);
        hread(6'h23, d);
        exp = 16'((m_flag << 4) | m_cptr);
        chk(d === exp, tag, d, exp);
        chk(irq === (m_flag & m_ie), {tag, " irq"}, irq, m_flag & m_ie);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!fin) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        for (int i = 0; i < 16; i++) begin
            m_rx[i] = '0;
            m_tx[i] = 16'((i * 16'h1357) ^ 16'hA5C3);
        end
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        // R1 reset state
        hread(6'h20, d); chk(d === 16'h0, "R1 ctrl after reset", d, 0);
        hread(6'h23, d); chk(d === 16'h0, "R1 status after reset", d, 0);
        chk(miso_oe === 1'b0, "R1 miso_oe after reset", miso_oe, 0);
        chk(irq === 1'b0, "R1 irq after reset", irq, 0);

        // R12 load transmit segment and read back
        for (int i = 0; i < 16; i++) hwrite(6'(i), m_tx[i]);
        hread(6'h05, d); chk(d === m_tx[5], "R12 tx readback", d, m_tx[5]);

        // R4 R6 R9 R10: three full words in one selection, stop at end
        set_start(0); set_end(2);
        set_ctrl(1, 0, 1, 0, 0, 0);
        ss_low();
        xbits(16'h1234, 16, "t2");
        xbits(16'hBEEF, 16, "t2");
        xbits(16'h0F0F, 16, "t2");
        ss_high();
        for (int e = 0; e < 3; e++) cmp_rx(e, "R4 R6 rx entry");
        cmp_stat("R9 status after end");
        hread(6'h20, d); chk(d[0] === 1'b0, "R10 enable cleared", d[0], 0);

        // R10 clocking while disabled is ignored
        ss_low();
        xbits(16'hFFFF, 16, "t3");
        ss_high();
        cmp_rx(3, "R10 entry 3 untouched");
        cmp_stat("R10 status unchanged");

        // R11 flag clear by host
        clear_flag();
        cmp_stat("R11 flag cleared");

        // R3 R5 R6: 8-bit words, split word, continuous selection
        set_start(3); set_end(5);
        set_ctrl(1, 0, 0, 0, 0, 8);
        ss_low();
        xbits(16'h005A, 8, "t4");
        xbits(16'h0005, 3, "t4");
        ss_high();
        cmp_rx(4, "R5 partial not stored");
        ss_low();
        xbits(16'h0013, 5, "t4");
        xbits(16'h00C3, 8, "t4");
        ss_high();
        cmp_rx(3, "R3 8-bit right-justified");
        cmp_rx(4, "R5 resumed entry");
        cmp_rx(5, "R6 rolled into next entry");
        cmp_stat("R9 second end");
        clear_flag();

        // R3 length 12 and out-of-range code 3 (means 8)
        set_start(6); set_end(15);
        set_ctrl(1, 0, 0, 0, 0, 12);
        ss_low();
        xbits(16'h0ABC, 12, "t5");
        ss_high();
        set_ctrl(1, 0, 0, 0, 0, 3);
        ss_low();
        xbits(16'h00E7, 8, "t5");
        ss_high();
        cmp_rx(6, "R3 12-bit word");
        cmp_rx(7, "R3 code 3 gives 8 bits");
        cmp_stat("R4 completed pointer 7");

        // R7 new start pointer discards partial word
        set_ctrl(1, 0, 0, 0, 0, 0);
        ss_low();
        xbits(16'h0015, 5, "t6");
        ss_high();
        set_start(10);
        ss_low();
        xbits(16'h9C3A, 16, "t6");
        ss_high();
        cmp_rx(8, "R7 old entry untouched");
        cmp_rx(10, "R7 new entry full word");
        cmp_stat("R7 completed pointer 10");

        // R8 the other three clock modes
        set_ctrl(1, 0, 0, 0, 1, 0);
        ss_low(); xbits(16'h6D21, 16, "t7m1"); ss_high();
        set_ctrl(1, 0, 0, 1, 0, 0);
        ss_low(); xbits(16'hE4B8, 16, "t7m2"); ss_high();
        set_ctrl(1, 0, 0, 1, 1, 0);
        ss_low(); xbits(16'h3F90, 16, "t7m3"); ss_high();
        for (int e = 11; e < 14; e++) cmp_rx(e, "R8 mode word");

        // R11 wraparound
        set_start(14); set_end(15);
        set_ctrl(1, 1, 1, 0, 0, 0);
        ss_low();
        xbits(16'h1111, 16, "t8");
        xbits(16'h2222, 16, "t8");
        xbits(16'h3333, 16, "t8");
        ss_high();
        cmp_rx(15, "R11 end entry");
        cmp_rx(0, "R11 wrapped to entry 0");
        cmp_stat("R11 flag after wrap");
        hread(6'h20, d); chk(d[0] === 1'b1, "R11 enable kept", d[0], 1);
        clear_flag();
        ss_low();
        xbits(16'h4444, 16, "t8");
        ss_high();
        cmp_rx(1, "R11 continued entry 1");
        cmp_stat("R11 flag stays clear");

        fin = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule